// File: doc/BRIEF.md
# Iterative Integer Divider with Deferred Sign Correction

This block is the integer divide unit of a 32-bit RISC-V style core. It performs signed and unsigned division and remainder on two 32-bit operands. Before the loop starts, the signed operands are turned into unsigned magnitudes. A restoring shift-and-subtract loop then produces one quotient bit per clock.

The cycle in which the loop ends only stores two things in registers: the unsigned quotient or remainder that the operation selected, and a sign-correction flag. A separate sign state reads both registers one clock later and forms the final result. This keeps the two's-complement negation out of the path of the last subtract. The cost is one extra clock on every operation.

The core pulses `start_i` with an operation code and both operands, then waits for `done_o`. `busy_o` shows when the unit is working, and the unit ignores new requests while it is working.

Top module: `div_seq_top`

## Requirements
- R1: `op_i` selects the operation. Bit 1 set means remainder and bit 1 clear means quotient. Bit 0 set means the operands are unsigned and bit 0 clear means they are two's-complement signed. So 00 is signed quotient, 01 is unsigned quotient, 10 is signed remainder and 11 is unsigned remainder.
- R2: A signed quotient is truncated toward zero, and its sign is the XOR of the two operand signs. A signed remainder takes the sign of the dividend.
- R3: When the divisor is zero, both quotient operations return 0xFFFFFFFF and both remainder operations return the dividend unchanged.
- R4: A signed divide of 0x80000000 by 0xFFFFFFFF (-1) returns 0x80000000 as the quotient and 0 as the remainder.
- R5: Suppose a request is accepted at rising edge N. Then `done_o` is high in the cycle that follows rising edge N+33: 32 iteration clocks, then one sign-correction clock.
- R6: `busy_o` goes high in the cycle after acceptance and stays high until the done cycle. It is low in the done cycle and whenever the unit is idle.
- R7: `done_o` is a single-cycle pulse. `result_o` changes only in a done cycle and keeps its value until the next operation completes.
- R8: A `start_i` that arrives while `busy_o` is high has no effect. The current operation finishes on schedule with its own operands, and the unit stays busy.
- R9: After reset, `busy_o` and `done_o` are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new operation; taken only when idle |
| op_i | input | 2 | Operation: bit 1 remainder, bit 0 unsigned |
| dividend_i | input | 32 | Dividend operand |
| divisor_i | input | 32 | Divisor operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Quotient or remainder, held between completions |

## Verification
A wrong iteration count or a state that runs too long or too short moves `done_o` off the exact cycle the reference model predicts, so it is reported in the first mismatching clock. A sign flag captured from the wrong source or at the wrong time shows up as a negated value in `result_o` in the done cycle of that operation. A request that is wrongly accepted mid-flight shows up either as a `busy_o` change or as a wrong result no later than 34 cycles after it. The comparison runs every clock, so a result register that moves outside a done cycle is reported in the cycle it moves.

// File: rtl/div_seq_pkg.sv
package div_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ITER = 2'd1,
      ST_SIGN = 2'd2
   } div_state_e;

   // bit 1: remainder wanted, bit 0: unsigned operands
   typedef struct packed {
      logic is_rem;
      logic is_unsigned;
   } div_op_t;

endpackage

// File: rtl/div_seq_prep.sv
module div_seq_prep
   import div_seq_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  div_op_t         op_i,
   input  logic [XLEN-1:0] dividend_i,
   input  logic [XLEN-1:0] divisor_i,
   output logic [XLEN-1:0] dvd_mag_o,
   output logic [XLEN-1:0] dvs_mag_o,
   output logic            sel_rem_o,
   output logic            fix_o
);

   generate
      if (XLEN < 4) begin : g_bad_xlen
         $error("div_seq_prep: XLEN must be at least 4");
      end
   endgenerate

   logic            dvd_neg;
   logic            dvs_neg;
   logic            dvs_zero;
   logic            fix_d;
   logic            sel_rem_q;
   logic            fix_q;

   assign dvd_neg  = !op_i.is_unsigned && dividend_i[XLEN-1];
   assign dvs_neg  = !op_i.is_unsigned && divisor_i[XLEN-1];
   assign dvs_zero = (divisor_i == '0);

   assign dvd_mag_o = dvd_neg ? (~dividend_i + 1'b1) : dividend_i;
   assign dvs_mag_o = dvs_neg ? (~divisor_i + 1'b1) : divisor_i;

   // remainder follows dividend; quotient follows sign xor, except for /0
   always_comb begin
      if (op_i.is_rem) begin
         fix_d = dvd_neg;
      end else begin
         fix_d = (dvd_neg ^ dvs_neg) && !dvs_zero;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_rem_q <= 1'b0;
         fix_q     <= 1'b0;
      end else if (load_i) begin
         sel_rem_q <= op_i.is_rem;
         fix_q     <= fix_d;
      end
   end

   assign sel_rem_o = sel_rem_q;
   assign fix_o     = fix_q;

   // R8
   op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(sel_rem_q) && $stable(fix_q));

endmodule

// File: rtl/div_seq_core.sv
module div_seq_core #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            step_i,
   input  logic [XLEN-1:0] dvd_mag_i,
   input  logic [XLEN-1:0] dvs_mag_i,
   output logic [XLEN-1:0] quo_nxt_o,
   output logic [XLEN-1:0] rem_nxt_o
);

   localparam int SW = XLEN + 1;

   generate
      if (XLEN < 4) begin : g_bad_xlen
         $error("div_seq_core: XLEN must be at least 4");
      end
   endgenerate

   logic [XLEN-1:0] rem_q;
   logic [XLEN-1:0] quo_q;
   logic [XLEN-1:0] dvs_q;
   logic [SW-1:0]   shifted;
   logic [SW-1:0]   trial;
   logic            fits;

   assign shifted   = {rem_q, quo_q[XLEN-1]};
   assign fits      = (shifted >= {1'b0, dvs_q});
   assign trial     = shifted - {1'b0, dvs_q};
   assign rem_nxt_o = fits ? trial[XLEN-1:0] : shifted[XLEN-1:0];
   assign quo_nxt_o = {quo_q[XLEN-2:0], fits};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         dvs_q <= '0;
      end else if (load_i) begin
         rem_q <= '0;
         quo_q <= dvd_mag_i;
         dvs_q <= dvs_mag_i;
      end else if (step_i) begin
         rem_q <= rem_nxt_o;
         quo_q <= quo_nxt_o;
      end
   end

   // R3
   zero_div_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && dvs_q == '0) |=> quo_q[0]);

   // R2
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && dvs_q != '0) |=> (rem_q < dvs_q));

endmodule

// File: rtl/div_seq_sign.sv
module div_seq_sign #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            capture_i,
   input  logic            apply_i,
   input  logic [XLEN-1:0] raw_i,
   input  logic            fix_i,
   output logic [XLEN-1:0] result_o,
   output logic            done_o
);

   generate
      if (XLEN < 4) begin : g_bad_xlen
         $error("div_seq_sign: XLEN must be at least 4");
      end
   endgenerate

   logic [XLEN-1:0] raw_q;
   logic            fix_q;
   logic [XLEN-1:0] res_q;
   logic            done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
         fix_q <= 1'b0;
      end else if (capture_i) begin
         raw_q <= raw_i;
         fix_q <= fix_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= apply_i;
         if (apply_i) begin
            res_q <= fix_q ? (~raw_q + 1'b1) : raw_q;
         end
      end
   end

   assign result_o = res_q;
   assign done_o   = done_q;

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> $stable(res_q));

   // R5
   capture_before_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture_i |=> apply_i);

endmodule

// File: rtl/div_seq_top.sv
module div_seq_top
   import div_seq_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [1:0]      op_i,
   input  logic [XLEN-1:0] dividend_i,
   input  logic [XLEN-1:0] divisor_i,
   output logic            busy_o,
   output logic            done_o,
   output logic [XLEN-1:0] result_o
);

   localparam int CNT_W = $clog2(XLEN);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(XLEN - 1);

   generate
      if ((XLEN & (XLEN - 1)) != 0) begin : g_bad_pow2
         $error("div_seq_top: XLEN must be a power of two");
      end
   endgenerate

   div_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic            load;
   logic            step;
   logic            capture;
   logic            apply;
   div_op_t         op;
   logic [XLEN-1:0] dvd_mag;
   logic [XLEN-1:0] dvs_mag;
   logic            sel_rem;
   logic            fix;
   logic [XLEN-1:0] quo_nxt;
   logic [XLEN-1:0] rem_nxt;
   logic [XLEN-1:0] raw_sel;

   assign op      = div_op_t'(op_i);
   assign load    = start_i && (state_q == ST_IDLE);
   assign step    = (state_q == ST_ITER);
   assign capture = step && (cnt_q == LAST);
   assign apply   = (state_q == ST_SIGN);
   assign raw_sel = sel_rem ? rem_nxt : quo_nxt;
   assign busy_o  = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (load) state_q <= ST_ITER;
            end
            ST_ITER: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST) state_q <= ST_SIGN;
            end
            ST_SIGN: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   div_seq_prep #(.XLEN(XLEN)) prep_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .op_i       (op),
      .dividend_i (dividend_i),
      .divisor_i  (divisor_i),
      .dvd_mag_o  (dvd_mag),
      .dvs_mag_o  (dvs_mag),
      .sel_rem_o  (sel_rem),
      .fix_o      (fix)
   );

   div_seq_core #(.XLEN(XLEN)) core_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .step_i    (step),
      .dvd_mag_i (dvd_mag),
      .dvs_mag_i (dvs_mag),
      .quo_nxt_o (quo_nxt),
      .rem_nxt_o (rem_nxt)
   );

   div_seq_sign #(.XLEN(XLEN)) sign_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture),
      .apply_i   (apply),
      .raw_i     (raw_sel),
      .fix_i     (fix),
      .result_o  (result_o),
      .done_o    (done_o)
   );

   // R6
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R5
   sign_after_iter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SIGN) |-> ($past(state_q) == ST_ITER && $past(cnt_q) == LAST));

   // R5
   done_after_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SIGN) |=> done_o);

   // R8
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ITER && start_i && cnt_q != LAST) |=>
         (state_q == ST_ITER && cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   // R9
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |-> (!busy_o && !done_o && result_o == '0));

endmodule

// File: tb/div_seq_top_tb.sv
module div_seq_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  op_i = 2'b00;
   logic [31:0] dividend_i = '0;
   logic [31:0] divisor_i = '0;
   logic        busy_o;
   logic        done_o;
   logic [31:0] result_o;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   div_seq_top #(.XLEN(32)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .op_i       (op_i),
      .dividend_i (dividend_i),
      .divisor_i  (divisor_i),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .result_o   (result_o)
   );

   // independent arithmetic reference
   function automatic logic [31:0] ref_div(input logic [1:0] op,
                                           input logic [31:0] a,
                                           input logic [31:0] b);
      int sa;
      int sb;
      if (b == 32'd0) return op[1] ? a : 32'hFFFF_FFFF;
      if (op == 2'b01) return a / b;
      if (op == 2'b11) return a % b;
      if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return op[1] ? 32'd0 : a;
      sa = int'(a);
      sb = int'(b);
      return op[1] ? 32'(sa % sb) : 32'(sa / sb);
   endfunction

   // cycle model
   logic        m_busy = 1'b0;
   logic        m_done = 1'b0;
   logic [31:0] m_res = '0;
   logic [31:0] m_pend = '0;
   int          m_cnt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy <= 1'b0;
         m_done <= 1'b0;
         m_res  <= '0;
         m_cnt  <= 0;
      end else begin
         m_done <= 1'b0;
         if (!m_busy && start_i) begin
            m_busy <= 1'b1;
            m_cnt  <= 33;
            m_pend <= ref_div(op_i, dividend_i, divisor_i);
         end else if (m_busy) begin
            if (m_cnt == 1) begin
               m_busy <= 1'b0;
               m_done <= 1'b1;
               m_res  <= m_pend;
            end
            m_cnt <= m_cnt - 1;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check("R6 busy", {31'd0, busy_o}, {31'd0, m_busy});
         check("R5 done", {31'd0, done_o}, {31'd0, m_done});
         check("R7 result", result_o, m_res);
      end
   end

   task automatic run_op(input string tag, input logic [1:0] op,
                         input logic [31:0] a, input logic [31:0] b,
                         input bit intrude);
      int n;
      logic [31:0] exp;
      exp = ref_div(op, a, b);
      @(negedge clk);
      start_i    = 1'b1;
      op_i       = op;
      dividend_i = a;
      divisor_i  = b;
      @(negedge clk);
      start_i    = 1'b0;
      n = 1;
      while (!done_o && n < 60) begin
         if (intrude && n == 10) begin
            start_i    = 1'b1;
            op_i       = ~op;
            dividend_i = ~a;
            divisor_i  = 32'd3;
         end else if (intrude && n == 12) begin
            start_i = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      start_i = 1'b0;
      check("R5 latency", 32'(n), 32'd34);
      check(tag, result_o, exp);
   endtask

   task automatic run_all_ops(input string tag, input logic [31:0] a, input logic [31:0] b);
      for (int k = 0; k < 4; k++) begin
         run_op(tag, 2'(k), a, b, 1'b0);
      end
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            // R9 reset state
            check("R9 busy", {31'd0, busy_o}, 32'd0);
            check("R9 done", {31'd0, done_o}, 32'd0);
            check("R9 result", result_o, 32'd0);
            rst_n = 1'b1;
            @(negedge clk);
            check("R9 idle after release", {30'd0, busy_o, done_o}, 32'd0);

            run_all_ops("R1 basic", 32'd20, 32'd6);
            run_all_ops("R2 neg dividend", 32'hFFFF_FFEC, 32'd6);
            run_all_ops("R2 neg divisor", 32'd20, 32'hFFFF_FFFA);
            run_all_ops("R2 both neg", 32'hFFFF_FFEC, 32'hFFFF_FFFA);
            run_all_ops("R3 zero divisor", 32'd7, 32'd0);
            run_all_ops("R3 zero divisor neg", 32'hFFFF_FFF9, 32'd0);
            run_all_ops("R4 overflow", 32'h8000_0000, 32'hFFFF_FFFF);
            run_all_ops("R1 large unsigned", 32'hFFFF_FFFF, 32'd1);
            run_all_ops("R1 zero dividend", 32'd0, 32'd5);
            run_all_ops("R1 small over big", 32'd5, 32'd7);
            run_all_ops("R1 all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF);

            // R8 start while busy
            run_op("R8 ignore start", 2'b00, 32'hFFFF_FF00, 32'd7, 1'b1);
            run_op("R8 ignore start", 2'b11, 32'd1000, 32'd33, 1'b1);

            for (int i = 0; i < 20; i++) begin
               run_op("R1 random", 2'(i), $urandom, (i % 3 == 0) ? 32'($urandom % 50) : $urandom, 1'b0);
            end

            // R7 result held while idle
            repeat (5) @(negedge clk);
            check("R7 hold idle", {31'd0, done_o}, 32'd0);
         end
         begin
            repeat (150000) @(posedge clk);
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule